// File: doc/BRIEF.md
# Flags-Image Push Unit

This unit prepares the flags word that a push-flags operation stores on the stack. It also decides whether the push may go ahead at all. A request arrives with four inputs: the full 64-bit flags register, the current processor mode, the requested operand size and the stack pointer. One clock later the unit presents four results: the edited image, the number of bytes to store, the decremented stack pointer and a write strobe.

In virtual-8086 mode the unit may refuse the push. Whether it does depends on three things taken together: the I/O privilege field, the virtual-mode extension enable and the operand size. When it refuses, it raises a general-protection fault flag instead of the write strobe. The fault always carries an error code of zero, so no code port is needed.

The memory write itself lies outside this unit. So do stack-limit checks and paging.

Top module: `flags_push_unit`

## Requirements
- R1: After reset, every output is zero.
- R2: The byte count depends on the operand-size code. Code 0 selects 16 bits and gives 2 bytes. Outside 64-bit mode, any other code gives 4 bytes. In 64-bit mode (mode code 3), any other code gives 8 bytes, so a 4-byte push never occurs there.
- R3: A request whose push is allowed is answered one cycle later. In that cycle the write strobe is high for exactly one cycle and the stack-pointer output equals the input stack pointer minus the byte count, modulo 2^SP_W.
- R4: In the image that is written, bit 17 (VM) and bit 16 (RF) are always zero, and every bit at or above the operand width is zero.
- R5: In real (code 0), protected (code 1) and 64-bit (code 3) modes, every other image bit below the operand width equals the flags input.
- R6: In virtual-8086 mode (code 2) with the privilege field (flags bits 13:12) equal to 3, the image is the same as under R5.
- R7: In virtual-8086 mode with privilege below 3, extension enabled and operand code 0, the push is allowed. Image bit 9 takes the value of flags bit 19 (VIF), image bits 13:12 read 3, and all other bits follow R4 and R5.
- R8: In virtual-8086 mode with privilege below 3 and either the extension disabled or an operand code other than 0, the fault flag is high for one cycle. In that cycle the write strobe is low, the stack-pointer output equals the input stack pointer, and both the image and the byte count are zero.
- R9: A cycle with no request produces a cycle with both the write strobe and the fault flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Push-flags request |
| flags_i | input | 64 | Current flags register |
| mode_i | input | 2 | 0 real, 1 protected, 2 virtual-8086, 3 64-bit |
| opsize_i | input | 2 | Operand-size code, 0 = 16-bit |
| vme_i | input | 1 | Virtual-mode extension enable |
| sp_i | input | SP_W | Stack pointer before the push |
| img_o | output | 64 | Image to store |
| nbytes_o | output | 4 | Bytes to store |
| sp_o | output | SP_W | Stack pointer after the push |
| wr_o | output | 1 | Write strobe |
| gp_o | output | 1 | General-protection fault, error code 0 |

## Verification
The bench builds the unit with the default SP_W of 64, so the full width of the stack-pointer subtraction is exercised. Directed cases drive a stack pointer of zero and of one, which forces a wrap through the top of the 64-bit range. Random stimulus covers every combination of mode, operand code, privilege field and extension bit, which means each of the three virtual-8086 outcomes is reached many times.

// File: rtl/flags_push_unit.sv
module flags_push_unit #(
  parameter int SP_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic [63:0]     flags_i,
  input  logic [1:0]      mode_i,
  input  logic [1:0]      opsize_i,
  input  logic            vme_i,
  input  logic [SP_W-1:0] sp_i,
  output logic [63:0]     img_o,
  output logic [3:0]      nbytes_o,
  output logic [SP_W-1:0] sp_o,
  output logic            wr_o,
  output logic            gp_o
);
  localparam int B_IF = 9, B_IOPL = 12, B_RF = 16, B_VM = 17, B_VIF = 19;

  logic        in_v86, in_long, word_op, low_priv, subst, fault;
  logic [3:0]  nb;
  logic [63:0] edited, width_mask;

  assign in_v86   = (mode_i == 2'd2);
  assign in_long  = (mode_i == 2'd3);
  assign word_op  = (opsize_i == 2'd0);
  assign low_priv = (flags_i[B_IOPL+1:B_IOPL] != 2'b11);
  assign subst    = in_v86 && low_priv && vme_i && word_op;
  assign fault    = in_v86 && low_priv && !(vme_i && word_op);
  assign nb       = word_op ? 4'd2 : (in_long ? 4'd8 : 4'd4);
  assign width_mask = word_op ? 64'h0000_0000_0000_FFFF :
                      (in_long ? '1 : 64'h0000_0000_FFFF_FFFF);

  always_comb begin
    edited = flags_i;
    edited[B_VM] = 1'b0;
    edited[B_RF] = 1'b0;
    if (subst) begin
      edited[B_IF] = flags_i[B_VIF];
      edited[B_IOPL+1:B_IOPL] = 2'b11;
    end
    edited = edited & width_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      img_o <= '0; nbytes_o <= '0; sp_o <= '0; wr_o <= 1'b0; gp_o <= 1'b0;
    end else begin
      wr_o <= req_i && !fault;
      gp_o <= req_i && fault;
      if (req_i) begin
        if (fault) begin
          img_o    <= '0;
          nbytes_o <= '0;
          sp_o     <= sp_i;
        end else begin
          img_o    <= edited;
          nbytes_o <= nb;
          sp_o     <= sp_i - SP_W'(nb);
        end
      end
    end
  end
endmodule

// File: rtl/flags_push_unit_chk.sv
module flags_push_unit_chk #(
  parameter int SP_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_i,
  input logic [1:0]      mode_i,
  input logic [SP_W-1:0] sp_i,
  input logic [63:0]     img_o,
  input logic [3:0]      nbytes_o,
  input logic [SP_W-1:0] sp_o,
  input logic            wr_o,
  input logic            gp_o
);
  AST_WR_GP_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(wr_o && gp_o)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !req_i |=> (!wr_o && !gp_o)); // R9
  AST_VM_RF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) wr_o |-> (img_o[17:16] == 2'b00)); // R4
  AST_FAULT_SP: assert property (@(posedge clk) disable iff (!rst_n) req_i |=> (gp_o -> (sp_o == $past(sp_i) && nbytes_o == 4'd0))); // R8
  AST_SP_DEC: assert property (@(posedge clk) disable iff (!rst_n) req_i |=> (wr_o -> (sp_o == $past(sp_i) - SP_W'(nbytes_o)))); // R3
  AST_LONG_NO32: assert property (@(posedge clk) disable iff (!rst_n) (req_i && mode_i == 2'd3) |=> (wr_o && nbytes_o != 4'd4)); // R2
  AST_COUNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) wr_o |-> (nbytes_o == 4'd2 || nbytes_o == 4'd4 || nbytes_o == 4'd8)); // R2
endmodule

bind flags_push_unit flags_push_unit_chk #(.SP_W(SP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i), .sp_i(sp_i),
  .img_o(img_o), .nbytes_o(nbytes_o), .sp_o(sp_o), .wr_o(wr_o), .gp_o(gp_o)
);

// File: tb/flags_push_unit_test.sv
`timescale 1ns/1ps
module flags_push_unit_test;
  localparam int SP_W = 64;
  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, vme = 1'b0;
  logic [63:0] flags = '0;
  logic [1:0] mode = '0, opsz = '0;
  logic [SP_W-1:0] sp = '0;
  logic [63:0] img;
  logic [3:0] nbytes;
  logic [SP_W-1:0] sp_out;
  logic wr, gp;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  flags_push_unit #(.SP_W(SP_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .flags_i(flags), .mode_i(mode),
    .opsize_i(opsz), .vme_i(vme), .sp_i(sp), .img_o(img), .nbytes_o(nbytes),
    .sp_o(sp_out), .wr_o(wr), .gp_o(gp)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
      $finish;
    end
  end

  function automatic logic exp_fault(logic [63:0] f, logic [1:0] m, logic [1:0] o, logic v);
    return (m == 2'd2) && (f[13:12] != 2'b11) && !(v && o == 2'd0);
  endfunction

  function automatic logic [3:0] exp_bytes(logic [1:0] m, logic [1:0] o);
    if (o == 2'd0) return 4'd2;
    return (m == 2'd3) ? 4'd8 : 4'd4;
  endfunction

  function automatic logic [63:0] exp_img(logic [63:0] f, logic [1:0] m, logic [1:0] o, logic v);
    logic [63:0] r;
    int w;
    r = f;
    r[17] = 1'b0;
    r[16] = 1'b0;
    if (m == 2'd2 && f[13:12] != 2'b11 && v && o == 2'd0) begin
      r[9] = f[19];
      r[13:12] = 2'b11;
    end
    w = 8 * exp_bytes(m, o);
    for (int i = 0; i < 64; i++) if (i >= w) r[i] = 1'b0;
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(logic [63:0] f, logic [1:0] m, logic [1:0] o, logic v, logic [SP_W-1:0] s);
    logic flt;
    string itag;
    @(negedge clk);
    req = 1'b1; flags = f; mode = m; opsz = o; vme = v; sp = s;
    @(negedge clk);
    req = 1'b0;
    flt = exp_fault(f, m, o, v);
    if (flt) begin
      check("R8 gp", 64'(gp), 64'd1);
      check("R8 wr", 64'(wr), 64'd0);
      check("R8 sp", 64'(sp_out), 64'(s));
      check("R8 img", img, 64'd0);
      check("R8 nbytes", 64'(nbytes), 64'd0);
    end else begin
      itag = (m == 2'd2) ? ((f[13:12] == 2'b11) ? "R6 img" : "R7 img") : "R5/R4 img";
      check("R3 wr", 64'(wr), 64'd1);
      check("R3 gp", 64'(gp), 64'd0);
      check("R2 nbytes", 64'(nbytes), 64'(exp_bytes(m, o)));
      check("R3 sp", 64'(sp_out), 64'(s - SP_W'(exp_bytes(m, o))));
      check(itag, img, exp_img(f, m, o, v));
    end
    @(negedge clk);
    check("R9 wr idle", 64'(wr), 64'd0);
    check("R9 gp idle", 64'(gp), 64'd0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R1 img", img, 64'd0);
    check("R1 nbytes", 64'(nbytes), 64'd0);
    check("R1 sp", 64'(sp_out), 64'd0);
    check("R1 wr", 64'(wr), 64'd0);
    check("R1 gp", 64'(gp), 64'd0);
    rst_n = 1'b1;
    // directed corners
    push('1, 2'd0, 2'd0, 1'b0, 64'd0);
    push('1, 2'd1, 2'd1, 1'b0, 64'd1);
    push('1, 2'd3, 2'd1, 1'b0, 64'h100);
    push('1, 2'd3, 2'd0, 1'b0, 64'h100);
    push(64'h0000_0000_0003_3200, 2'd2, 2'd1, 1'b0, 64'h80);
    push(64'h0000_0000_0008_0000, 2'd2, 2'd0, 1'b1, 64'h80);
    push(64'h0000_0000_0003_1200, 2'd2, 2'd0, 1'b1, 64'h80);
    push(64'h0000_0000_0000_1000, 2'd2, 2'd0, 1'b0, 64'h80);
    push(64'h0000_0000_0000_0000, 2'd2, 2'd1, 1'b1, 64'h80);
    for (int k = 0; k < 600; k++)
      push({$urandom, $urandom}, 2'($urandom), 2'($urandom), 1'($urandom),
           {$urandom, $urandom});
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule